// File: doc/BRIEF.md
# Power-of-Two Oversampling Averager

This block takes a stream of 12-bit conversion samples and folds a power-of-two batch of them into one averaged value. A 4-bit exponent input N sets the batch size to 2^N. Each accepted sample is added into a wide running sum. When the last sample of a batch arrives, the sum is shifted right by N and the low 12 bits are offered on a result port. That port uses a valid/ready handshake and stands in for a memory write.

Two single-cycle event outputs mark progress. One fires for every raw sample taken. The other fires when an averaged value is written out, which is the cycle of the result handshake. The control is a two-state machine. `COLLECT` is the reset state; in it the block accumulates samples. The transition `BATCH_DONE` (the last sample of a batch is accepted) moves it to `OFFER`. In `OFFER` the result is held. The transition `WRITTEN` (the result handshake completes) returns it to `COLLECT`. A change of the exponent while in `COLLECT` flushes the partial batch.

Top module: `ovs_avg`

## Requirements
- R1: A sample on `smp_data` (12 bits) is taken in a cycle where `smp_valid` and `smp_ready` are both high. `smp_ready` is high in `COLLECT`, except in the one cycle in which `cfg_exp` differs from its value in the previous cycle.
- R2: Each result equals floor(sum / 2^N) of the 2^N samples taken since the previous result, for N = 0..8. Exponent values 9..15 behave as 8.
- R3: The 20-bit running sum cannot overflow. A batch of 256 samples of 0xFFF yields 0xFFF.
- R4: `evt_sample` is high for exactly one cycle, in the cycle after each taken sample, and is low otherwise.
- R5: `evt_result` is high exactly in a cycle where `res_valid` and `res_ready` are both high, which happens once per result. After that cycle `res_valid` is low.
- R6: Individual samples are never emitted. `res_valid` rises only after the 2^N-th sample of a batch is taken.
- R7: With N = 0 each sample passes straight through. With `res_ready` high, `evt_sample` and `evt_result` are high in the same cycle.
- R8: While `res_valid` is high and `res_ready` is low, the following hold: `res_valid` stays high, `res_data` is stable, `evt_result` is low, and `smp_ready` is low. No sample is lost.
- R9: A change of `cfg_exp` in the middle of a batch discards the partial sum and restarts the sample count.
- R10: A synchronous reset (`rst` high) clears the sum, the count, `res_valid`, `evt_sample` and `evt_result`, and enters `COLLECT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_exp | input | 4 | Oversample exponent N |
| smp_valid | input | 1 | Sample present |
| smp_data | input | 12 | Sample value |
| smp_ready | output | 1 | Block can take a sample |
| res_valid | output | 1 | Averaged value offered |
| res_data | output | 12 | Averaged value |
| res_ready | input | 1 | Sink takes the result |
| evt_sample | output | 1 | Pulse per taken sample |
| evt_result | output | 1 | Pulse per written result |

## Verification
The properties assume that `cfg_exp` changes only while no batch is being offered. They also assume that `res_ready`, once low with a result pending, is released eventually. The bench changes the exponent only between batches, or in the middle of a batch after all pending results are drained. It drives every input at the falling edge. It also holds `smp_valid` with stable data until `smp_ready` has been seen high at a rising edge.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
    typedef enum logic [0:0] {
        ST_COLLECT = 1'b0,
        ST_OFFER   = 1'b1
    } ovs_state_e;
endpackage

// File: rtl/ovs_cfgwatch.sv
module ovs_cfgwatch #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXP_W-1:0] cfg_exp,
    output logic             flush
);
    logic [EXP_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        cfg_q <= cfg_exp;
    end

    // no flush while in reset: the register is loaded from the live value
    assign flush = !rst && (cfg_q != cfg_exp);
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum #(
    parameter int DATA_W  = 12,
    parameter int MAX_EXP = 8,
    parameter int EXP_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take,
    input  logic [EXP_W-1:0]  shamt,
    input  logic [DATA_W-1:0] din,
    output logic              last,
    output logic [DATA_W-1:0] avg
);
    localparam int ACC_W = DATA_W + MAX_EXP;
    localparam int CNT_W = MAX_EXP + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        sum  = acc_q + ACC_W'(din);
        mask = (CNT_W'(1) << shamt) - CNT_W'(1);
        last = (cnt_q == mask);
        avg  = DATA_W'(sum >> shamt);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            if (last) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= sum;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ovs_ctrl.sv
module ovs_ctrl
    import ovs_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              smp_valid,
    input  logic              last,
    input  logic [DATA_W-1:0] avg,
    input  logic              res_ready,
    output logic              take,
    output logic              smp_ready,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              evt_sample,
    output logic              evt_result
);
    ovs_state_e state_q;
    ovs_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (take && last) state_d = ST_OFFER;   // BATCH_DONE
            ST_OFFER:   if (res_ready)    state_d = ST_COLLECT; // WRITTEN
            default:    state_d = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_COLLECT;
        else     state_q <= state_d;
    end

    always_comb begin
        smp_ready  = (state_q == ST_COLLECT) && !flush;
        take       = smp_ready && smp_valid;
        res_valid  = (state_q == ST_OFFER);
        evt_result = res_valid && res_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data   <= '0;
            evt_sample <= 1'b0;
        end else begin
            evt_sample <= take;
            if (take && last) res_data <= avg;
        end
    end
endmodule

// File: rtl/ovs_avg.sv
module ovs_avg #(
    parameter int DATA_W  = 12,
    parameter int MAX_EXP = 8,
    parameter int EXP_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EXP_W-1:0]  cfg_exp,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              smp_ready,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    input  logic              res_ready,
    output logic              evt_sample,
    output logic              evt_result
);
    logic             flush;
    logic             take;
    logic             last;
    logic [DATA_W-1:0] avg;
    logic [EXP_W-1:0] shamt;

    assign shamt = (cfg_exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : cfg_exp;

    ovs_cfgwatch #(.EXP_W(EXP_W)) u_watch (
        .clk(clk), .rst(rst), .cfg_exp(cfg_exp), .flush(flush)
    );

    ovs_accum #(.DATA_W(DATA_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_accum (
        .clk(clk), .rst(rst), .clr(flush), .take(take), .shamt(shamt),
        .din(smp_data), .last(last), .avg(avg)
    );

    ovs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst), .flush(flush), .smp_valid(smp_valid),
        .last(last), .avg(avg), .res_ready(res_ready), .take(take),
        .smp_ready(smp_ready), .res_valid(res_valid), .res_data(res_data),
        .evt_sample(evt_sample), .evt_result(evt_result)
    );
endmodule

// File: rtl/ovs_avg_chk.sv
module ovs_avg_chk #(
    parameter int DATA_W = 12,
    parameter int EXP_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [EXP_W-1:0]  cfg_exp,
    input logic              smp_valid,
    input logic              smp_ready,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              res_ready,
    input logic              evt_sample,
    input logic              evt_result
);
    p_ready_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_exp != $past(cfg_exp)) |-> !smp_ready);

    p_pulse_on_r4: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_ready) |=> evt_sample);

    p_pulse_off_r4: assert property (@(posedge clk) disable iff (rst)
        !(smp_valid && smp_ready) |=> !evt_sample);

    p_retire_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ready) |=> (!res_valid && !evt_result));

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

    p_block_input_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !smp_ready);

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!res_valid && !evt_sample && !evt_result));
endmodule

bind ovs_avg ovs_avg_chk #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/ovs_avg_tb.sv
module ovs_avg_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_exp = 4'd0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        smp_ready;
    logic        res_valid;
    logic [11:0] res_data;
    logic        res_ready = 1'b1;
    logic        evt_sample;
    logic        evt_result;

    int applied = 0;
    int fails = 0;
    int n_smp = 0;
    int n_res = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ovs_avg u_dut (.*);

    // {exponent, first sample, step, expected average}
    localparam logic [39:0] VEC [0:7] = '{
        {4'd0,  12'hABC, 12'd0,  12'hABC},
        {4'd1,  12'd100, 12'd1,  12'd100},
        {4'd2,  12'hFFF, 12'd0,  12'hFFF},
        {4'd3,  12'd0,   12'd10, 12'd35},
        {4'd8,  12'hFFF, 12'd0,  12'hFFF},
        {4'd4,  12'd1000,12'd3,  12'd1022},
        {4'd2,  12'd7,   12'd1,  12'd8},
        {4'd12, 12'h800, 12'd0,  12'h800}
    };

    always @(negedge clk) if (!rst) begin
        if (evt_sample) n_smp++;
        if (evt_result) n_res++;
    end

    task automatic check(input string req, input int act, input int exp);
        applied++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] d);
        bit ok;
        smp_valid = 1'b1;
        smp_data  = d;
        forever begin
            #1 ok = smp_ready;
            @(negedge clk);
            if (ok) break;
        end
        smp_valid = 1'b0;
    endtask

    task automatic set_exp(input logic [3:0] e);
        @(negedge clk);
        cfg_exp = e;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_result();
        while (!res_valid) @(negedge clk);
        #1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10 res_valid after reset", res_valid, 0);
        check("R10 evt_sample after reset", evt_sample, 0);
        check("R10 evt_result after reset", evt_result, 0);
        rst = 1'b0;
        @(negedge clk);
        #1 check("R1 ready in COLLECT", smp_ready, 1);

        foreach (VEC[k]) begin
            int e, cnt, s0, r0;
            logic [11:0] st, sp, ex;
            {e, st, sp, ex} = {28'd0, VEC[k]};
            {st, sp, ex} = VEC[k][35:0];
            e = int'(VEC[k][39:36]);
            set_exp(4'(e));
            cnt = 1 << ((e > 8) ? 8 : e);
            s0 = n_smp; r0 = n_res;
            for (int i = 0; i < cnt; i++) begin
                if (i == cnt - 1) check("R6 no early result", res_valid, 0);
                push(st + 12'(i) * sp);
            end
            wait_result();
            if (e == 0) begin
                check("R7 sample event same cycle", evt_sample, 1);
                check("R7 result event same cycle", evt_result, 1);
            end
            check("R2 R3 average value", res_data, ex);
            @(negedge clk); #1;
            check("R4 sample event count", n_smp - s0, cnt);
            check("R5 result event count", n_res - r0, 1);
            check("R5 valid drops after write", res_valid, 0);
        end

        // back-pressure
        set_exp(4'd1);
        res_ready = 1'b0;
        push(12'd10);
        push(12'd20);
        repeat (4) @(negedge clk);
        #1;
        check("R8 valid held", res_valid, 1);
        check("R8 data held", res_data, 15);
        check("R8 input blocked", smp_ready, 0);
        check("R8 no result event", evt_result, 0);
        fork
            push(12'd40);
            begin
                repeat (3) @(negedge clk);
                #2 res_ready = 1'b1;
                #1 check("R5 event on handshake", evt_result, 1);
            end
        join
        push(12'd60);
        wait_result();
        check("R8 no sample lost", res_data, 50);
        @(negedge clk);

        // mid-batch exponent change
        set_exp(4'd2);
        push(12'd4000);
        push(12'd4000);
        set_exp(4'd1);
        check("R9 partial not emitted", res_valid, 0);
        push(12'd5);
        push(12'd7);
        wait_result();
        check("R9 restart after change", res_data, 6);
        @(negedge clk);

        // reset mid-batch
        push(12'd4000);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 check("R10 no event after reset", evt_sample, 0);
        push(12'd2);
        push(12'd4);
        wait_result();
        check("R10 sum cleared by reset", res_data, 3);
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule